// File: doc/BRIEF.md
# Transmit Buffer Priority Scheduler

This block decides which of several pending transmit message buffers a CAN protocol engine sends next. Each buffer has a request level driven by software and a 2-bit priority. The scheduler does not sample these settings ahead of time. In the cycle where the engine strobes start of frame, it compares every requested buffer. It then latches the winner and holds that choice until the frame ends.

During a frame the block reports which buffer is in flight, as an index with a valid flag and as a one-hot status vector. The frame can end in three ways: completion, lost arbitration or abort. On completion the block sends a one-cycle clear pulse for the buffer's request. After lost arbitration the request stays set, so the buffer competes again at the next start of frame. On abort the block sends clear pulses for every pending request except the one in flight. Message storage, bit timing and bus arbitration belong to the engine.

Top module: `can_tx_prio_sched`

## Requirements
- R1: During and after reset, with no start of frame seen, `sel_vld_o` is 0, `sel_idx_o` is 0, `tx_busy_o` is 0 and `req_clr_o` is 0.
- R2: When `sof_i` is high, no frame is active, `abort_i` is low and at least one `req_i` bit is set, the choice is latched at that clock edge. From the next cycle `sel_vld_o` is 1, `sel_idx_o` gives the chosen buffer and `tx_busy_o` has only that buffer's bit set.
- R3: Buffer k's priority is `prio_i[2k+1:2k]`. Among requested buffers the numerically largest priority wins: 2'b11 highest, 2'b10 and 2'b01 intermediate, 2'b00 lowest.
- R4: Among requested buffers that share the top priority, the buffer with the highest index wins.
- R5: The choice is made from the `req_i` and `prio_i` values present in the start-of-frame cycle, so a change applied in that same cycle takes effect.
- R6: `sof_i` has no effect while a frame is active. It also has no effect when no request is set.
- R7: `done_i` during an active frame ends it. In the next cycle `sel_vld_o` and `tx_busy_o` are 0 and `req_clr_o` pulses for one cycle with only the finished buffer's bit set.
- R8: `arb_lost_i` during an active frame ends it without any `req_clr_o` pulse. At the next start of frame that buffer competes again.
- R9: `abort_i` ends any active frame. One cycle later `req_clr_o` pulses with the bits `req_i & ~tx_busy_o` sampled in the abort cycle, so the buffer in flight is spared.
- R10: While a frame is active and none of `done_i`, `abort_i` or `arb_lost_i` is high, `sel_idx_o` holds its value whatever happens on `req_i` and `prio_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NBUF | Transmit request level per buffer |
| prio_i | input | NBUF*PW | Priority per buffer, buffer k at bits [PW*k +: PW] |
| sof_i | input | 1 | Start-of-frame strobe from the protocol engine |
| done_i | input | 1 | Frame completed successfully |
| abort_i | input | 1 | Abort pending transmissions |
| arb_lost_i | input | 1 | Arbitration lost on the bus |
| sel_idx_o | output | IDX_W | Index of the buffer in flight |
| sel_vld_o | output | 1 | A frame is active |
| tx_busy_o | output | NBUF | One-hot transmitting status |
| req_clr_o | output | NBUF | One-cycle request-clear pulses |

## Verification
Every result is due exactly one clock edge after the input that causes it. This applies to the latched selection after `sof_i`, the end of status after `done_i`, `arb_lost_i` or `abort_i`, and the clear pulse. The clear pulse must also be gone one edge later. The bench changes inputs on the falling edge and samples on the next falling edge, so each check lands in the cycle where the result is due. It then samples once more to confirm that pulses last a single cycle and that ignored strobes leave the outputs unchanged.

// File: rtl/can_txs_pkg.sv
package can_txs_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } txs_state_e;
endpackage

// File: rtl/txs_prio_pick.sv
module txs_prio_pick #(
  parameter int NBUF  = 3,
  parameter int PW    = 2,
  parameter int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic [NBUF-1:0]    req_i,
  input  logic [NBUF*PW-1:0] prio_i,
  output logic               win_vld_o,
  output logic [IDX_W-1:0]   win_idx_o,
  output logic [PW-1:0]      win_prio_o
);
  // ">=" lets a later (higher-index) buffer take a tie
  always_comb begin
    win_vld_o  = 1'b0;
    win_idx_o  = '0;
    win_prio_o = '0;
    for (int k = 0; k < NBUF; k++) begin
      if (req_i[k] && (!win_vld_o || prio_i[k*PW +: PW] >= win_prio_o)) begin
        win_vld_o  = 1'b1;
        win_idx_o  = IDX_W'(k);
        win_prio_o = prio_i[k*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/txs_frame_track.sv
module txs_frame_track
  import can_txs_pkg::*;
#(
  parameter int NBUF  = 3,
  parameter int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NBUF-1:0]  req_i,
  input  logic             sof_i,
  input  logic             done_i,
  input  logic             abort_i,
  input  logic             arb_lost_i,
  input  logic             win_vld_i,
  input  logic [IDX_W-1:0] win_idx_i,
  output logic [IDX_W-1:0] sel_idx_o,
  output logic             sel_vld_o,
  output logic [NBUF-1:0]  tx_busy_o,
  output logic [NBUF-1:0]  req_clr_o
);
  txs_state_e       st_q;
  logic [IDX_W-1:0] sel_q;
  logic [NBUF-1:0]  clr_q, clr_d, sel_oh;
  logic             start, finish;

  assign sel_oh = NBUF'(1) << sel_q;
  assign start  = (st_q == ST_IDLE) && sof_i && win_vld_i && !abort_i;
  assign finish = (st_q == ST_BUSY) && (done_i || abort_i || arb_lost_i);

  always_comb begin
    clr_d = '0;
    if (st_q == ST_BUSY) begin
      if (done_i)  clr_d = clr_d | sel_oh;
      if (abort_i) clr_d = clr_d | (req_i & ~sel_oh);
    end else if (abort_i) begin
      clr_d = req_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      sel_q <= '0;
      clr_q <= '0;
    end else begin
      clr_q <= clr_d;
      if (start) begin
        st_q  <= ST_BUSY;
        sel_q <= win_idx_i;
      end else if (finish) begin
        st_q  <= ST_IDLE;
      end
    end
  end

  assign sel_idx_o = sel_q;
  assign sel_vld_o = (st_q == ST_BUSY);
  assign tx_busy_o = (st_q == ST_BUSY) ? sel_oh : '0;
  assign req_clr_o = clr_q;

  p_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_vld_o && sof_i && win_vld_i && !abort_i) |=> (sel_vld_o && sel_idx_o == $past(win_idx_i)));
  p_sof_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_vld_o && sof_i && !win_vld_i) |=> !sel_vld_o);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_vld_o && !done_i && !abort_i && !arb_lost_i) |=> (sel_vld_o && $stable(sel_idx_o)));
  p_done_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_vld_o && done_i) |=> (!sel_vld_o && req_clr_o[$past(sel_idx_o)]));
  p_arb_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_vld_o && arb_lost_i && !done_i && !abort_i) |=> (!sel_vld_o && req_clr_o == '0));
  p_abort_spare_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_vld_o && abort_i && !done_i) |=> ((req_clr_o & $past(tx_busy_o)) == '0));
endmodule

// File: rtl/can_tx_prio_sched.sv
module can_tx_prio_sched #(
  parameter int NBUF  = 3,
  parameter int PW    = 2,
  parameter int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NBUF-1:0]    req_i,
  input  logic [NBUF*PW-1:0] prio_i,
  input  logic               sof_i,
  input  logic               done_i,
  input  logic               abort_i,
  input  logic               arb_lost_i,
  output logic [IDX_W-1:0]   sel_idx_o,
  output logic               sel_vld_o,
  output logic [NBUF-1:0]    tx_busy_o,
  output logic [NBUF-1:0]    req_clr_o
);
  logic             win_vld;
  logic [IDX_W-1:0] win_idx;
  logic [PW-1:0]    win_prio;

  txs_prio_pick #(.NBUF(NBUF), .PW(PW), .IDX_W(IDX_W)) u_pick (
    .req_i      (req_i),
    .prio_i     (prio_i),
    .win_vld_o  (win_vld),
    .win_idx_o  (win_idx),
    .win_prio_o (win_prio)
  );

  txs_frame_track #(.NBUF(NBUF), .IDX_W(IDX_W)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .sof_i      (sof_i),
    .done_i     (done_i),
    .abort_i    (abort_i),
    .arb_lost_i (arb_lost_i),
    .win_vld_i  (win_vld),
    .win_idx_i  (win_idx),
    .sel_idx_o  (sel_idx_o),
    .sel_vld_o  (sel_vld_o),
    .tx_busy_o  (tx_busy_o),
    .req_clr_o  (req_clr_o)
  );

  // every requested buffer loses to the latched one on priority, or ties with a lower index
  for (genvar k = 0; k < NBUF; k++) begin : g_order
    p_prio_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sel_vld_o && sof_i && !abort_i && req_i[k]) |=>
        (sel_vld_o &&
         (($past(prio_i[k*PW +: PW]) < $past(win_prio)) ||
          ($past(prio_i[k*PW +: PW]) == $past(win_prio) && IDX_W'(k) <= sel_idx_o))));
  end
endmodule

// File: tb/can_tx_prio_sched_tb_top.sv
module can_tx_prio_sched_tb_top;
  localparam int NBUF = 3;
  localparam int PW   = 2;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [NBUF-1:0]  req_i = '0;
  logic [NBUF*PW-1:0] prio_i = '0;
  logic             sof_i = 1'b0, done_i = 1'b0, abort_i = 1'b0, arb_lost_i = 1'b0;
  logic [1:0]       sel_idx_o;
  logic             sel_vld_o;
  logic [NBUF-1:0]  tx_busy_o, req_clr_o;

  int checks = 0;
  int failures = 0;

  always #10 clk_i = ~clk_i;

  can_tx_prio_sched #(.NBUF(NBUF), .PW(PW)) dut_i (
    .clk_i, .rst_ni, .req_i, .prio_i, .sof_i, .done_i, .abort_i, .arb_lost_i,
    .sel_idx_o, .sel_vld_o, .tx_busy_o, .req_clr_o
  );

  // {req[2:0], prio {b2,b1,b0}, expected index}
  localparam logic [10:0] VEC [8] = '{
    {3'b001, 6'b00_00_00, 2'd0},
    {3'b111, 6'b01_11_10, 2'd1},
    {3'b111, 6'b11_11_11, 2'd2},
    {3'b011, 6'b11_00_00, 2'd1},
    {3'b101, 6'b00_11_01, 2'd0},
    {3'b110, 6'b10_10_11, 2'd2},
    {3'b100, 6'b00_11_11, 2'd2},
    {3'b011, 6'b00_01_10, 2'd0}
  };

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk("R1 valid", sel_vld_o, 0);
    chk("R1 idx", sel_idx_o, 0);
    chk("R1 busy", tx_busy_o, 0);
    chk("R1 clr", req_clr_o, 0);
    rst_ni = 1'b1;
    tick();

    // table walk: R2 R3 R4 R7
    for (int v = 0; v < 8; v++) begin
      req_i  = VEC[v][10:8];
      prio_i = VEC[v][7:2];
      sof_i  = 1'b1;
      tick();
      sof_i  = 1'b0;
      chk($sformatf("R2 vld v%0d", v), sel_vld_o, 1);
      chk($sformatf("R3/R4 idx v%0d", v), sel_idx_o, VEC[v][1:0]);
      chk($sformatf("R2 busy v%0d", v), tx_busy_o, 3'b001 << VEC[v][1:0]);
      done_i = 1'b1;
      tick();
      done_i = 1'b0;
      chk($sformatf("R7 clr v%0d", v), req_clr_o, 3'b001 << VEC[v][1:0]);
      chk($sformatf("R7 end v%0d", v), {sel_vld_o, tx_busy_o}, 0);
      tick();
      chk($sformatf("R7 pulse v%0d", v), req_clr_o, 0);
      req_i = '0;
      tick();
    end

    // R6: sof with nothing requested
    sof_i = 1'b1;
    tick();
    sof_i = 1'b0;
    chk("R6 no req", {sel_vld_o, tx_busy_o}, 0);

    // R5: priority changed in the start-of-frame cycle
    req_i  = 3'b111;
    prio_i = 6'b00_00_11;
    tick();
    prio_i = 6'b11_00_00;
    sof_i  = 1'b1;
    tick();
    sof_i  = 1'b0;
    chk("R5 late prio", sel_idx_o, 2);

    // R10 / R6: changes and a second sof during the frame
    prio_i = 6'b00_11_00;
    req_i  = 3'b011;
    sof_i  = 1'b1;
    tick();
    sof_i  = 1'b0;
    chk("R10 hold idx", sel_idx_o, 2);
    chk("R6 busy sof", tx_busy_o, 3'b100);

    // R8: lost arbitration keeps the request, competes again
    req_i = 3'b111;
    prio_i = 6'b11_00_00;
    arb_lost_i = 1'b1;
    tick();
    arb_lost_i = 1'b0;
    chk("R8 end", sel_vld_o, 0);
    chk("R8 no clr", req_clr_o, 0);
    sof_i = 1'b1;
    tick();
    sof_i = 1'b0;
    chk("R8 again", sel_idx_o, 2);

    // R9: abort spares the buffer in flight
    abort_i = 1'b1;
    tick();
    abort_i = 1'b0;
    chk("R9 clr", req_clr_o, 3'b011);
    chk("R9 end", sel_vld_o, 0);
    tick();
    chk("R9 pulse", req_clr_o, 0);

    // R9: abort while idle clears all pending
    req_i = 3'b101;
    abort_i = 1'b1;
    sof_i = 1'b1;
    tick();
    abort_i = 1'b0;
    sof_i = 1'b0;
    chk("R9 idle clr", req_clr_o, 3'b101);
    chk("R9 no start", sel_vld_o, 0);
    req_i = '0;
    tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule